// File: doc/BRIEF.md
# Bidirectional Common-Line Scan Register

This block forms the row scan path of a matrix display driver. A chain of selection bits, one per common line, moves a selection token along the lines. Each line's bit, combined with the alternating-phase input, is turned into a two-bit drive-level code that an analog switch stage outside the block would decode. Several devices can be cascaded: the serial pin at the far end of the chain hands the token on to the next device.

The shift clock is an ordinary input sampled by the system clock. Every high-to-low transition seen on it moves the chain by one place. A direction input selects which of the two serial pins receives data and which one sends it. The pins are modelled as separate input, output and output-enable signals, so an external pad cell can realise them as true bidirectional pins. A blanking input forces every line to the idle level without disturbing the stored bits.

Top module: `comscan_top`

## Requirements
- R1: The chain moves by exactly one place in the system clock cycle in which `shiftClk` is first sampled low after being sampled high. In every other cycle outside reset it holds its contents.
- R2: With `scanRev` = 0, the bit shifted in comes from `leftIn` and lands in line 1. Each line n takes the previous value of line n-1, and line LINES's old value is dropped.
- R3: With `scanRev` = 1, the bit shifted in comes from `rightIn` and lands in line LINES. Each line n takes the previous value of line n+1, and line 1's old value is dropped.
- R4: With `scanRev` = 0, `rightOe` = 1, `leftOe` = 0 and `rightOut` shows line LINES. With `scanRev` = 1, `leftOe` = 1, `rightOe` = 0 and `leftOut` shows line 1. The out signal of the pin that is not driving is 0.
- R5: Line n's code sits at `lineLevel[2n-1:2n-2]`, with V1=00, V2=01, V3=10 and V4=11. With `acPhase` = 0, a selected line (bit 1) gives V2 and an unselected line gives V3. With `acPhase` = 1, a selected line gives V1 and an unselected line gives V4.
- R6: While `blankN` = 0, every line code is V1. The stored bits are kept, and the codes return to the R5 mapping of those bits when `blankN` goes high again.
- R7: A cycle with `rst` = 1 clears every stored bit to 0 on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shiftClk | input | 1 | Shift clock; a falling transition moves the chain |
| scanRev | input | 1 | Scan direction: 0 moves data from line 1 toward line LINES, 1 moves it the other way |
| acPhase | input | 1 | Alternating drive phase |
| blankN | input | 1 | Active-low blanking |
| leftIn | input | 1 | Left serial pin, input side |
| leftOut | output | 1 | Left serial pin, output side |
| leftOe | output | 1 | Left serial pin output enable |
| rightIn | input | 1 | Right serial pin, input side |
| rightOut | output | 1 | Right serial pin, output side |
| rightOe | output | 1 | Right serial pin output enable |
| lineLevel | output | 2*LINES | Drive-level code per line, two bits each |

## Verification
A single token is walked through all lines in both directions, past the far pin. This separates a correct shift order from a reversed or off-by-one chain, and it shows whether the token leaves on the right pin. A dense pattern of adjacent ones and zeros catches bits that are dropped or duplicated. Holding the shift clock high while the serial inputs toggle tells a true falling-edge detector apart from one that reacts to levels or to rising edges. Blanking during a loaded pattern, flipping the phase, and resetting in the middle of a scan separate the output mapping from the stored state.

// File: rtl/comscan_pkg.sv
package comscan_pkg;

  typedef enum logic [1:0] {
    LVL_V1 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V3 = 2'b10,
    LVL_V4 = 2'b11
  } drvLevel_t;

  localparam int LVL_W = 2;

  typedef struct packed {
    logic shiftEn;
    logic towardLow;
    logic serIn;
    logic blank;
    logic phase;
  } scanCtl_t;

endpackage

// File: rtl/comscan_ctrl.sv
module comscan_ctrl
  import comscan_pkg::*;
(
  input  logic     clk,
  input  logic     shiftClk,
  input  logic     scanRev,
  input  logic     acPhase,
  input  logic     blankN,
  input  logic     leftIn,
  input  logic     rightIn,
  output scanCtl_t ctl,
  output logic     leftOe,
  output logic     rightOe
);

  logic shClkQ;

  always_ff @(posedge clk) begin
    shClkQ <= shiftClk;
  end

  always_comb begin
    ctl.shiftEn   = shClkQ & ~shiftClk;
    ctl.towardLow = scanRev;
    ctl.serIn     = scanRev ? rightIn : leftIn;
    ctl.blank     = ~blankN;
    ctl.phase     = acPhase;
  end

  assign leftOe  = scanRev;
  assign rightOe = ~scanRev;

endmodule

// File: rtl/comscan_path.sv
module comscan_path
  import comscan_pkg::*;
#(
  parameter int LINES = 80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  scanCtl_t               ctl,
  output logic [LINES-1:0]       lineSel,
  output logic [LVL_W*LINES-1:0] lineLevel
);

  logic [LINES-1:0] selQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      selQ <= '0;
    end else if (ctl.shiftEn) begin
      if (ctl.towardLow) selQ <= {ctl.serIn, selQ[LINES-1:1]};
      else               selQ <= {selQ[LINES-2:0], ctl.serIn};
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    drvLevel_t lvl;
    always_comb begin
      if (ctl.blank)        lvl = LVL_V1;
      else if (ctl.phase)   lvl = selQ[i] ? LVL_V1 : LVL_V4;
      else                  lvl = selQ[i] ? LVL_V2 : LVL_V3;
    end
    assign lineLevel[LVL_W*i +: LVL_W] = lvl;
  end

  assign lineSel = selQ;

endmodule

// File: rtl/comscan_top.sv
module comscan_top
  import comscan_pkg::*;
#(
  parameter int LINES = 80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shiftClk,
  input  logic                   scanRev,
  input  logic                   acPhase,
  input  logic                   blankN,
  input  logic                   leftIn,
  output logic                   leftOut,
  output logic                   leftOe,
  input  logic                   rightIn,
  output logic                   rightOut,
  output logic                   rightOe,
  output logic [LVL_W*LINES-1:0] lineLevel
);

  scanCtl_t         ctl;
  logic [LINES-1:0] lineSel;

  comscan_ctrl u_ctrl (
    .clk(clk), .shiftClk(shiftClk), .scanRev(scanRev), .acPhase(acPhase),
    .blankN(blankN), .leftIn(leftIn), .rightIn(rightIn), .ctl(ctl),
    .leftOe(leftOe), .rightOe(rightOe)
  );

  comscan_path #(.LINES(LINES)) u_path (
    .clk(clk), .rst(rst), .ctl(ctl), .lineSel(lineSel), .lineLevel(lineLevel)
  );

  assign leftOut  = leftOe  & lineSel[0];
  assign rightOut = rightOe & lineSel[LINES-1];

endmodule

// File: rtl/comscan_chk.sv
module comscan_chk #(
  parameter int LINES = 80
) (
  input logic               clk,
  input logic               rst,
  input logic               shiftClk,
  input logic               scanRev,
  input logic               acPhase,
  input logic               blankN,
  input logic               leftIn,
  input logic               rightIn,
  input logic               leftOut,
  input logic               rightOut,
  input logic               leftOe,
  input logic               rightOe,
  input logic [LINES-1:0]   lineSel,
  input logic [2*LINES-1:0] lineLevel
);

  logic rstSeen = 1'b0;
  always_ff @(posedge clk) rstSeen <= rst;

  // R7
  always_ff @(posedge clk) begin
    if (rstSeen) reset_clear_chk: assert (lineSel == '0);
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !($past(shiftClk) && !shiftClk) |=> $stable(lineSel));

  // R2
  fwd_shift_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(shiftClk) && !shiftClk && !scanRev) |=>
      (lineSel == {$past(lineSel[LINES-2:0]), $past(leftIn)}));

  // R3
  rev_shift_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(shiftClk) && !shiftClk && scanRev) |=>
      (lineSel == {$past(rightIn), $past(lineSel[LINES-1:1])}));

  // R4
  pin_role_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({leftOe, rightOe}) == 1 &&
    (scanRev ? (leftOut == lineSel[0] && !rightOut)
             : (rightOut == lineSel[LINES-1] && !leftOut)));

  // R6
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    !blankN |-> lineLevel == '0);

  // R5
  first_line_chk: assert property (@(posedge clk) disable iff (rst)
    blankN |-> lineLevel[1:0] ==
      (acPhase ? (lineSel[0] ? 2'b00 : 2'b11) : (lineSel[0] ? 2'b01 : 2'b10)));

  // R5
  last_line_chk: assert property (@(posedge clk) disable iff (rst)
    blankN |-> lineLevel[2*LINES-1 -: 2] ==
      (acPhase ? (lineSel[LINES-1] ? 2'b00 : 2'b11)
               : (lineSel[LINES-1] ? 2'b01 : 2'b10)));

endmodule

bind comscan_top comscan_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .shiftClk(shiftClk), .scanRev(scanRev),
  .acPhase(acPhase), .blankN(blankN), .leftIn(leftIn), .rightIn(rightIn),
  .leftOut(leftOut), .rightOut(rightOut), .leftOe(leftOe), .rightOe(rightOe),
  .lineSel(lineSel), .lineLevel(lineLevel)
);

// File: tb/comscan_top_bench.sv
module comscan_top_bench;

  localparam int LINES = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftClk = 1'b0, scanRev = 1'b0, acPhase = 1'b0, blankN = 1'b1;
  logic leftIn = 1'b0, rightIn = 1'b0;
  logic leftOut, leftOe, rightOut, rightOe;
  logic [2*LINES-1:0] lineLevel;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R7";

  int model[$];
  int prevClk = 0;

  always #5 clk = ~clk;

  comscan_top #(.LINES(LINES)) u_comscan_top (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .scanRev(scanRev),
    .acPhase(acPhase), .blankN(blankN), .leftIn(leftIn), .leftOut(leftOut),
    .leftOe(leftOe), .rightIn(rightIn), .rightOut(rightOut),
    .rightOe(rightOe), .lineLevel(lineLevel)
  );

  function automatic logic [1:0] expLevel(int bitv);
    if (!blankN) return 2'b00;
    if (acPhase) return bitv != 0 ? 2'b00 : 2'b11;
    return bitv != 0 ? 2'b01 : 2'b10;
  endfunction

  initial begin
    for (int i = 0; i < LINES; i++) model.push_back(0);
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) model[i] = 0;
    end else if (prevClk != 0 && shiftClk == 1'b0) begin
      if (!scanRev) begin
        model.push_front(int'(leftIn));
        void'(model.pop_back());
      end else begin
        model.push_back(int'(rightIn));
        void'(model.pop_front());
      end
    end
    prevClk = int'(shiftClk);
    #2;
    if (!done) begin
      logic [2*LINES-1:0] expLv;
      logic eLo, eLoOe, eRo, eRoOe;
      for (int i = 0; i < LINES; i++) expLv[2*i +: 2] = expLevel(model[i]);
      checks++;
      if (lineLevel !== expLv) begin
        fails++;
        $display("FAIL %s line levels: actual %h expected %h", tag, lineLevel, expLv);
      end
      eLoOe = scanRev;
      eRoOe = !scanRev;
      eLo = scanRev && model[0] != 0;
      eRo = !scanRev && model[LINES-1] != 0;
      checks++;
      if ({leftOe, leftOut, rightOe, rightOut} !== {eLoOe, eLo, eRoOe, eRo}) begin
        fails++;
        $display("FAIL R4 pins {lOe,lOut,rOe,rOut}: actual %b expected %b",
                 {leftOe, leftOut, rightOe, rightOut}, {eLoOe, eLo, eRoOe, eRo});
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(logic din);
    @(negedge clk);
    shiftClk = 1'b1;
    if (scanRev) rightIn = din; else leftIn = din;
    @(negedge clk);
    @(negedge clk);
    shiftClk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    idle(3);
    tag = "R7";
    rst = 1'b0;
    idle(2);

    // R2 and R5: single token walked forward past the right pin
    tag = "R2";
    step(1'b1);
    for (int i = 0; i < LINES + 2; i++) begin
      if (i == 40) acPhase = 1'b1;
      step(1'b0);
    end
    tag = "R5";
    acPhase = 1'b0;
    step(1'b1);
    acPhase = 1'b1;
    idle(2);

    // R2: dense pattern
    tag = "R2";
    for (int i = 0; i < 12; i++) step(((i % 3) != 1) ? 1'b1 : 1'b0);

    // R6: blank keeps contents
    tag = "R6";
    blankN = 1'b0;
    idle(4);
    step(1'b1);
    idle(2);
    blankN = 1'b1;
    idle(3);

    // R1: shift clock held high while inputs toggle
    tag = "R1";
    @(negedge clk);
    shiftClk = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      leftIn = ~leftIn;
      rightIn = ~rightIn;
    end
    shiftClk = 1'b0;
    idle(3);

    // R3: reverse scan
    tag = "R3";
    scanRev = 1'b1;
    idle(2);
    step(1'b1);
    for (int i = 0; i < LINES + 2; i++) step((i % 7 == 3) ? 1'b1 : 1'b0);

    // R7: reset mid-scan
    tag = "R7";
    step(1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle(3);
    scanRev = 1'b0;
    step(1'b1);
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule